// File: doc/BRIEF.md
# Machine-Mode Trap Entry Unit

This is the trap controller for a single-issue, non-pipelined 32-bit core that runs only at the highest privilege level. Each cycle the core presents the instruction it is retiring: its address, a flag that says the instruction reached its end, four synchronous fault flags (misaligned fetch, illegal opcode, breakpoint, environment call) and a return-from-trap flag. Two interrupt request lines, a timer line and an external line, come from outside the instruction stream.

The unit decides whether this cycle ends in a trap. If it does, it saves a resume address and a cause code, pushes the global interrupt enable onto a one-deep stack and steers the next fetch to the trap vector. A synchronous fault keeps the faulting instruction's own address, with no hardware advance. An interrupt keeps the address of the first instruction that has not yet run. On the return instruction the unit sends fetch back to the saved address exactly as it is stored, so a handler that wants to skip a call or breakpoint must advance the address itself. The four trap registers can also be read and written through a small register port.

Top module: `trap_unit`

## Requirements
- R1: When a synchronous fault is taken, the saved resume address equals the faulting instruction's own address with bits 1:0 cleared. This also holds for environment call and breakpoint.
- R2: The cause register holds bit 31 clear for faults. The codes are 0 for misaligned fetch, 2 for illegal opcode, 3 for breakpoint and 11 for environment call. When several fault flags are set together, the priority is misaligned > illegal > breakpoint > call.
- R3: An interrupt is taken only in a cycle where an instruction retires. The saved address is that instruction's address + 4. The cause is 0x80000007 for timer and 0x8000000B for external, and external wins when both are accepted.
- R4: When a fault and an accepted interrupt arrive in the same cycle, the fault is taken. The interrupt stays pending and is taken after a later retiring instruction.
- R5: An interrupt is accepted only when the global enable and that source's enable are both 1. Otherwise it has no effect: there is no redirect and the cause and status registers keep their values.
- R6: On trap entry, the previous-enable bit takes the old global enable and the global enable clears. In the same cycle redirect_o is 1 and redirect_pc_o is the vector register with bits 1:0 forced to 0.
- R7: On return, redirect_pc_o equals the saved address unmodified. The global enable takes the previous-enable bit, and the previous-enable bit is set to 1. No interrupt is accepted in the return cycle.
- R8: The register port uses address 0 for status, 1 for vector, 2 for saved address and 3 for cause. Status bits are: bit 0 global enable, bit 1 previous enable, bit 2 timer enable, bit 3 external enable, and all other bits read 0. A write to the saved address clears bits 1:0. Reads are combinational, and every register resets to 0.
- R9: A software write in the same cycle as a trap entry or a return is discarded.
- R10: When retire_valid_i is 0, nothing happens: no fault or interrupt is taken and no return is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_valid_i | input | 1 | Instruction at retire_pc_i retires this cycle |
| retire_pc_i | input | 32 | Address of the retiring instruction |
| flt_misalign_i | input | 1 | Misaligned fetch fault |
| flt_illegal_i | input | 1 | Illegal opcode fault |
| flt_break_i | input | 1 | Breakpoint instruction |
| flt_call_i | input | 1 | Environment call instruction |
| ret_i | input | 1 | Return-from-trap instruction |
| irq_timer_i | input | 1 | Timer interrupt request |
| irq_ext_i | input | 1 | External interrupt request |
| csr_we_i | input | 1 | Register port write strobe |
| csr_addr_i | input | 2 | Register select |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data |
| redirect_o | output | 1 | Fetch must be redirected next |
| redirect_pc_o | output | 32 | Redirect target |

## Verification
Each fault flag is driven alone, and then in pairs, to show that the code and the priority come from the right flag and that the saved address never moves. Interrupts are driven with every combination of global and per-source enable, and with both lines at once. This separates correct gating from plain forwarding, and the external-over-timer order from the reverse. A fault together with a live interrupt, and a return together with a live interrupt, show which event wins and that the losing interrupt is still taken later. Software writes that collide with a trap or a return show that the hardware update wins.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned FLT_N = 4;

  typedef enum logic [1:0] {
    CSR_STATUS = 2'd0,
    CSR_VECTOR = 2'd1,
    CSR_EPC    = 2'd2,
    CSR_CAUSE  = 2'd3
  } csr_sel_e;

  typedef struct packed {
    logic ext_en;
    logic tmr_en;
    logic pie;
    logic gie;
  } status_t;

  localparam logic [4:0] CODE_MISALIGN = 5'd0;
  localparam logic [4:0] CODE_ILLEGAL  = 5'd2;
  localparam logic [4:0] CODE_BREAK    = 5'd3;
  localparam logic [4:0] CODE_CALL     = 5'd11;
  localparam logic [4:0] CODE_TMR_IRQ  = 5'd7;
  localparam logic [4:0] CODE_EXT_IRQ  = 5'd11;

  // index 0 is the highest priority fault
  function automatic logic [4:0] flt_code(input int unsigned idx);
    case (idx)
      0:       return CODE_MISALIGN;
      1:       return CODE_ILLEGAL;
      2:       return CODE_BREAK;
      default: return CODE_CALL;
    endcase
  endfunction
endpackage

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            retire_valid_i,
  input  logic [XLEN-1:0] retire_pc_i,
  input  logic [FLT_N-1:0] flt_i,
  input  logic            ret_i,
  input  logic            irq_timer_i,
  input  logic            irq_ext_i,
  input  status_t         status_i,
  output logic            flt_take_o,
  output logic            irq_take_o,
  output logic            ret_take_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o
);
  localparam int unsigned AW = XLEN - 2;

  logic            any_flt;
  logic            ext_ok, tmr_ok;
  logic [4:0]      flt_code_w, irq_code_w;
  logic [AW-1:0]   word_addr;

  assign any_flt    = |flt_i;
  assign ext_ok     = irq_ext_i & status_i.ext_en;
  assign tmr_ok     = irq_timer_i & status_i.tmr_en;

  assign flt_take_o = retire_valid_i & any_flt;
  assign ret_take_o = retire_valid_i & ret_i & ~any_flt;
  assign irq_take_o = retire_valid_i & ~any_flt & ~ret_i & status_i.gie & (ext_ok | tmr_ok);

  always_comb begin
    flt_code_w = CODE_CALL;
    for (int i = FLT_N - 1; i >= 0; i--) begin
      if (flt_i[i]) flt_code_w = flt_code(i);
    end
  end

  assign irq_code_w = ext_ok ? CODE_EXT_IRQ : CODE_TMR_IRQ;

  always_comb begin
    cause_o = '0;
    if (flt_take_o) begin
      cause_o[4:0] = flt_code_w;
    end else begin
      cause_o[XLEN-1] = 1'b1;
      cause_o[4:0]    = irq_code_w;
    end
  end

  // faults keep their own address; interrupts resume at the next instruction
  assign word_addr = retire_pc_i[XLEN-1:2] + (flt_take_o ? AW'(0) : AW'(1));
  assign epc_o     = {word_addr, 2'b00};

  AST_FLT_BLOCKS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_flt |-> !irq_take_o); // R4
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (status_i.gie && (irq_ext_i || irq_timer_i))); // R5
  AST_IDLE_NO_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_valid_i |-> !(flt_take_o || irq_take_o || ret_take_o)); // R10
  AST_RET_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_take_o |-> !irq_take_o); // R7
endmodule

// File: rtl/trap_csr_regs.sv
module trap_csr_regs
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_i,
  input  logic            ret_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic            csr_we_i,
  input  csr_sel_e        csr_sel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output status_t         status_o,
  output logic [XLEN-1:0] vector_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] csr_rdata_o
);
  localparam int unsigned SW = $bits(status_t);

  status_t         status_q;
  logic [XLEN-1:0] vector_q, epc_q, cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      vector_q <= '0;
      epc_q    <= '0;
      cause_q  <= '0;
    end else if (trap_i) begin
      status_q.pie <= status_q.gie;
      status_q.gie <= 1'b0;
      epc_q        <= epc_i;
      cause_q      <= cause_i;
    end else if (ret_i) begin
      status_q.gie <= status_q.pie;
      status_q.pie <= 1'b1;
    end else if (csr_we_i) begin
      case (csr_sel_i)
        CSR_STATUS: status_q <= status_t'(csr_wdata_i[SW-1:0]);
        CSR_VECTOR: vector_q <= csr_wdata_i;
        CSR_EPC:    epc_q    <= {csr_wdata_i[XLEN-1:2], 2'b00};
        default:    cause_q  <= csr_wdata_i;
      endcase
    end
  end

  always_comb begin
    case (csr_sel_i)
      CSR_STATUS: csr_rdata_o = {{(XLEN-SW){1'b0}}, status_q};
      CSR_VECTOR: csr_rdata_o = vector_q;
      CSR_EPC:    csr_rdata_o = epc_q;
      default:    csr_rdata_o = cause_q;
    endcase
  end

  assign status_o = status_q;
  assign vector_o = vector_q;
  assign epc_o    = epc_q;

  AST_ENTRY_STACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (!status_q.gie && status_q.pie == $past(status_q.gie))); // R6
  AST_RET_UNSTACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i |=> (status_q.gie == $past(status_q.pie) && status_q.pie)); // R7
  AST_SW_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && (trap_i || ret_i)) |=> $stable(vector_q)); // R9
  AST_EPC_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !trap_i && !ret_i && csr_sel_i == CSR_EPC) |=> epc_q[1:0] == 2'b00); // R8
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            retire_valid_i,
  input  logic [XLEN-1:0] retire_pc_i,
  input  logic            flt_misalign_i,
  input  logic            flt_illegal_i,
  input  logic            flt_break_i,
  input  logic            flt_call_i,
  input  logic            ret_i,
  input  logic            irq_timer_i,
  input  logic            irq_ext_i,
  input  logic            csr_we_i,
  input  logic [1:0]      csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o
);
  logic [FLT_N-1:0] flt_vec;
  logic             flt_take, irq_take, ret_take, trap_take;
  logic [XLEN-1:0]  cause_w, epc_w, vector_q, epc_q;
  status_t          status_q;

  assign flt_vec   = {flt_call_i, flt_break_i, flt_illegal_i, flt_misalign_i};
  assign trap_take = flt_take | irq_take;

  trap_select #(.XLEN(XLEN)) u_sel (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .retire_valid_i (retire_valid_i),
    .retire_pc_i    (retire_pc_i),
    .flt_i          (flt_vec),
    .ret_i          (ret_i),
    .irq_timer_i    (irq_timer_i),
    .irq_ext_i      (irq_ext_i),
    .status_i       (status_q),
    .flt_take_o     (flt_take),
    .irq_take_o     (irq_take),
    .ret_take_o     (ret_take),
    .cause_o        (cause_w),
    .epc_o          (epc_w)
  );

  trap_csr_regs #(.XLEN(XLEN)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trap_i      (trap_take),
    .ret_i       (ret_take),
    .cause_i     (cause_w),
    .epc_i       (epc_w),
    .csr_we_i    (csr_we_i),
    .csr_sel_i   (csr_sel_e'(csr_addr_i)),
    .csr_wdata_i (csr_wdata_i),
    .status_o    (status_q),
    .vector_o    (vector_q),
    .epc_o       (epc_q),
    .csr_rdata_o (csr_rdata_o)
  );

  assign redirect_o    = trap_take | ret_take;
  assign redirect_pc_o = trap_take ? {vector_q[XLEN-1:2], 2'b00} : epc_q;

  AST_FLT_EPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_take |=> epc_q == {$past(retire_pc_i[XLEN-1:2]), 2'b00}); // R1
  AST_IRQ_EPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take |=> epc_q == {$past(retire_pc_i[XLEN-1:2]) + 1'b1, 2'b00}); // R3
  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flt_take, irq_take, ret_take})); // R4
endmodule

// File: tb/sim_trap_unit.sv
`timescale 1ns/1ps
module sim_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rv = 1'b0;
  logic [31:0] pc = '0;
  logic        f_mis = 0, f_ill = 0, f_brk = 0, f_call = 0, f_ret = 0;
  logic        irq_t = 0, irq_e = 0;
  logic        we = 0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        redir;
  logic [31:0] redir_pc;
  logic        s_redir;
  logic [31:0] s_pc;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  trap_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .retire_valid_i(rv), .retire_pc_i(pc),
    .flt_misalign_i(f_mis), .flt_illegal_i(f_ill), .flt_break_i(f_brk),
    .flt_call_i(f_call), .ret_i(f_ret), .irq_timer_i(irq_t), .irq_ext_i(irq_e),
    .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .redirect_o(redir), .redirect_pc_o(redir_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic csr_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // one retire cycle; flags = {ret, call, brk, ill, mis}
  task automatic step(input logic v, input logic [31:0] p, input logic [4:0] flags,
                      input logic swe, input logic [1:0] sa, input logic [31:0] sd);
    @(negedge clk);
    rv = v; pc = p; {f_ret, f_call, f_brk, f_ill, f_mis} = flags;
    we = swe; addr = sa; wdata = sd;
    #1 s_redir = redir; s_pc = redir_pc;
    @(posedge clk); #1;
    rv = 0; {f_ret, f_call, f_brk, f_ill, f_mis} = '0; we = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      csr_rd(2'(a), d); chk("R8 reset value", d, 32'h0);
    end
  endtask

  task automatic t_call;
    logic [31:0] d;
    csr_wr(2'd1, 32'h0000_0101);
    csr_wr(2'd0, 32'h1);
    step(1, 32'h2000, 5'b01000, 0, 0, 0);
    chk("R6 redirect", {31'b0, s_redir}, 32'h1);
    chk("R6 vector low bits", s_pc, 32'h100);
    csr_rd(2'd2, d); chk("R1 call epc", d, 32'h2000);
    csr_rd(2'd3, d); chk("R2 call cause", d, 32'd11);
    csr_rd(2'd0, d); chk("R6 status stack", d, 32'h2);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    step(1, 32'h3004, 5'b00110, 0, 0, 0);
    csr_rd(2'd3, d); chk("R2 illegal over break", d, 32'd2);
    csr_rd(2'd2, d); chk("R1 illegal epc", d, 32'h3004);
    step(1, 32'h3008, 5'b01100, 0, 0, 0);
    csr_rd(2'd3, d); chk("R2 break over call", d, 32'd3);
    step(1, 32'h3002, 5'b01001, 0, 0, 0);
    csr_rd(2'd3, d); chk("R2 misalign over call", d, 32'd0);
    csr_rd(2'd2, d); chk("R1 misalign epc cleared", d, 32'h3000);
  endtask

  task automatic t_return;
    logic [31:0] d;
    csr_wr(2'd2, 32'h2007);
    csr_rd(2'd2, d); chk("R8 epc write clears low bits", d, 32'h2004);
    csr_wr(2'd0, 32'h2);
    step(1, 32'h150, 5'b10000, 0, 0, 0);
    chk("R7 return redirect", {31'b0, s_redir}, 32'h1);
    chk("R7 return target", s_pc, 32'h2004);
    csr_rd(2'd0, d); chk("R7 unstack", d, 32'h3);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    csr_wr(2'd0, 32'h5);
    irq_t = 1;
    step(1, 32'h400, 5'b0, 0, 0, 0);
    chk("R3 timer redirect", s_pc, 32'h100);
    csr_rd(2'd2, d); chk("R3 timer epc pc+4", d, 32'h404);
    csr_rd(2'd3, d); chk("R3 timer cause", d, 32'h8000_0007);
    csr_rd(2'd0, d); chk("R6 irq stack", d, 32'h6);
    csr_wr(2'd0, 32'hD);
    irq_e = 1;
    step(1, 32'h600, 5'b0, 0, 0, 0);
    csr_rd(2'd3, d); chk("R3 external over timer", d, 32'h8000_000B);
    csr_rd(2'd2, d); chk("R3 external epc", d, 32'h604);
    irq_t = 0; irq_e = 0;
  endtask

  task automatic t_gating;
    logic [31:0] d;
    csr_wr(2'd3, 32'h55);
    csr_wr(2'd0, 32'h1);
    irq_t = 1;
    step(1, 32'h700, 5'b0, 0, 0, 0);
    chk("R5 source disabled no redirect", {31'b0, s_redir}, 32'h0);
    csr_rd(2'd3, d); chk("R5 source disabled cause kept", d, 32'h55);
    csr_wr(2'd0, 32'h4);
    step(1, 32'h704, 5'b0, 0, 0, 0);
    chk("R5 global disabled no redirect", {31'b0, s_redir}, 32'h0);
    csr_rd(2'd0, d); chk("R5 status kept", d, 32'h4);
    irq_t = 0;
  endtask

  task automatic t_flt_vs_irq;
    logic [31:0] d;
    csr_wr(2'd0, 32'h9);
    irq_e = 1;
    step(1, 32'h500, 5'b00010, 0, 0, 0);
    csr_rd(2'd3, d); chk("R4 fault wins cause", d, 32'd2);
    csr_rd(2'd2, d); chk("R4 fault wins epc", d, 32'h500);
    csr_wr(2'd0, 32'h9);
    step(1, 32'h504, 5'b0, 0, 0, 0);
    csr_rd(2'd3, d); chk("R4 irq taken later", d, 32'h8000_000B);
    csr_rd(2'd2, d); chk("R4 irq later epc", d, 32'h508);
    irq_e = 0;
  endtask

  task automatic t_no_retire;
    logic [31:0] d;
    csr_wr(2'd3, 32'h77);
    csr_wr(2'd0, 32'h9);
    irq_e = 1;
    step(0, 32'h800, 5'b01000, 0, 0, 0);
    chk("R10 idle no redirect", {31'b0, s_redir}, 32'h0);
    csr_rd(2'd3, d); chk("R10 idle cause kept", d, 32'h77);
    irq_e = 0;
  endtask

  task automatic t_collide;
    logic [31:0] d;
    step(1, 32'h900, 5'b00100, 1, 2'd3, 32'h1234);
    csr_rd(2'd3, d); chk("R9 trap beats cause write", d, 32'd3);
    csr_wr(2'd0, 32'h9);
    irq_e = 1;
    step(1, 32'h910, 5'b10000, 1, 2'd1, 32'h4440);
    chk("R7 return beats pending irq", s_pc, 32'h900);
    csr_rd(2'd1, d); chk("R9 return drops vector write", d, 32'h101);
    csr_rd(2'd3, d); chk("R7 no irq at return", d, 32'd3);
    irq_e = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_call();
    t_priority();
    t_return();
    t_irq();
    t_gating();
    t_flt_vs_irq();
    t_no_retire();
    t_collide();
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule